// File: doc/BRIEF.md
# PLL Power and Retune Sequencer

This block drives the digital control bits of a single PLL: supply enable, output isolation, oscillator enable, an active-low reset release, the fine tuner enable and the feedback-word change strobe. It also holds the post-divider code and the feedback word that the PLL reads. Three commands are accepted when the sequencer is idle: bring the PLL up, take it down, and retune it to a new feedback word and output divide ratio.

Every wait is a count of reference-clock cycles. Each wait is set in microseconds and scaled by a ticks-per-microsecond parameter. A command is taken on a clock edge where `cmd_valid` is high. A `busy` level covers the whole sequence, and a one-cycle `done` pulse ends it. The `pll_ready` output shows that the PLL is up and not being retuned. A command that cannot be taken produces a one-cycle `cmd_err` pulse and has no other effect.

Top module: `pll_seq`

## Requirements
- R1: After reset, all of these are low: `pwr_on`, `pll_en`, `rst_b`, `tuner_en`, `chg_strobe`, `busy`, `done`, `pll_ready`, `pdiv_code` and `pll_word`. `iso_en` is high.
- R2: A power-up command (`cmd_op`=1) is accepted only while powered down. `pwr_on` rises on the accepting edge. `iso_en` falls PON_US*TICKS_PER_US cycles later. `pll_en` rises ISO_US*TICKS_PER_US cycles after that. `tuner_en` rises one cycle after `pll_en`.
- R3: SETTLE_US*TICKS_PER_US cycles after `tuner_en` rises, the power-up ends. On that edge `rst_b` rises if HAS_RSTB is set; otherwise it stays low.
- R4: A power-down command (`cmd_op`=2) is accepted only while running. It changes one output on each edge, in this order: `rst_b` low on the accepting edge, then `tuner_en` low, then `pll_en` low, then `iso_en` high, then `pwr_on` low.
- R5: A retune command (`cmd_op`=3) is accepted in either idle state. `tuner_en` falls on the accepting edge. `pdiv_code` is written one edge later and `pll_word` two edges later. `chg_strobe` rises together with `pll_word`, and only if `pll_en` was high when the command was taken.
- R6: `pdiv_code` is the 3-bit base-2 logarithm of the 8-bit `cmd_ratio`. It is the index of the highest set bit, and 0 when `cmd_ratio` is 0.
- R7: Retune while running: `tuner_en` returns high one edge after the word write. `chg_strobe` stays high for a further SETTLE_US*TICKS_PER_US cycles and then clears on the final edge. Retune while stopped: `tuner_en` stays low, `chg_strobe` never rises, and the sequence ends on the edge after the word write.
- R8: The sequencer rejects a command in any of these cases: it is busy; the op is 0; power-up is requested while running; power-down is requested while stopped. A rejected command gives `cmd_err` high for the one cycle after its edge and changes no other output.
- R9: `busy` is high from the accepting edge until the edge that ends the sequence. On that ending edge `done` is high for exactly one cycle.
- R10: `pll_ready` is high only while the PLL is up and no sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 1 power-up, 2 power-down, 3 retune |
| cmd_word | input | WORD_W | New feedback word for retune |
| cmd_ratio | input | 2**PDIV_W | Output divide ratio for retune (power of two) |
| pwr_on | output | 1 | PLL supply enable |
| iso_en | output | 1 | Output isolation, high = isolated |
| pll_en | output | 1 | Oscillator enable |
| rst_b | output | 1 | Active-low reset release |
| tuner_en | output | 1 | Fine tuner enable |
| chg_strobe | output | 1 | Feedback-word change strobe |
| pdiv_code | output | PDIV_W | Post-divider code (log2 of ratio) |
| pll_word | output | WORD_W | Feedback word applied to the PLL |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| cmd_err | output | 1 | One-cycle rejected-command pulse |
| pll_ready | output | 1 | PLL up and idle |

## Verification
Every output is registered, so a result from the command accepted on edge 1 is first visible in the half cycle after that edge. With the default parameters, the results of a power-up are due at these offsets: `pwr_on` at 1, `iso_en` at 11, `pll_en` at 21, `tuner_en` at 22, and `rst_b` with `done` at 222. A power-down is due at offsets 1 to 5, a retune of a running PLL at 1, 2, 3, 4 and 204, and a retune of a stopped PLL at 1 to 4. The bench drives and samples on falling edges. It counts falling edges from the command and records the first offset at which each output changes, then compares each recorded offset with the expected one. A rejected command must show `cmd_err` at offset 1.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [3:0] {
        S_OFF,
        S_UP_PWR,
        S_UP_ISO,
        S_UP_TUN,
        S_UP_SETTLE,
        S_ON,
        S_DN_TUN,
        S_DN_EN,
        S_DN_ISO,
        S_DN_PWR,
        S_RT_PDIV,
        S_RT_WORD,
        S_RT_TUN,
        S_RT_SETTLE
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_UP     = 2'd1,
        OP_DOWN   = 2'd2,
        OP_RETUNE = 2'd3
    } seq_op_e;

endpackage

// File: rtl/pll_seq_wait.sv
// Down-counting wait timer: load with N-1 to remain N cycles in a state.
module pll_seq_wait #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pll_seq_pdiv_enc.sv
// Divide ratio to post-divider code: index of the highest set bit.
module pll_seq_pdiv_enc #(
    parameter int CODE_W = 3,
    localparam int RATIO_W = 1 << CODE_W
) (
    input  logic [RATIO_W-1:0] ratio,
    output logic [CODE_W-1:0]  code
);
    always_comb begin
        code = '0;
        for (int i = 0; i < RATIO_W; i++) begin
            if (ratio[i]) code = CODE_W'(i);
        end
    end
endmodule

// File: rtl/pll_seq.sv
module pll_seq
    import pll_seq_pkg::*;
#(
    parameter int WORD_W        = 22,
    parameter int PDIV_W        = 3,
    parameter int TICKS_PER_US  = 10,
    parameter int PON_US        = 1,
    parameter int ISO_US        = 1,
    parameter int SETTLE_US     = 20,
    parameter bit HAS_RSTB      = 1'b1,
    localparam int RATIO_W      = 1 << PDIV_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [WORD_W-1:0]  cmd_word,
    input  logic [RATIO_W-1:0] cmd_ratio,
    output logic               pwr_on,
    output logic               iso_en,
    output logic               pll_en,
    output logic               rst_b,
    output logic               tuner_en,
    output logic               chg_strobe,
    output logic [PDIV_W-1:0]  pdiv_code,
    output logic [WORD_W-1:0]  pll_word,
    output logic               busy,
    output logic               done,
    output logic               cmd_err,
    output logic               pll_ready
);
    localparam int W_PON    = PON_US * TICKS_PER_US;
    localparam int W_ISO    = ISO_US * TICKS_PER_US;
    localparam int W_SETTLE = SETTLE_US * TICKS_PER_US;
    localparam int W_MAX0   = (W_PON > W_ISO) ? W_PON : W_ISO;
    localparam int W_MAX    = (W_MAX0 > W_SETTLE) ? W_MAX0 : W_SETTLE;
    localparam int CNT_W    = $clog2(W_MAX + 1);
    localparam logic [CNT_W-1:0] LD_PON    = CNT_W'(W_PON - 1);
    localparam logic [CNT_W-1:0] LD_ISO    = CNT_W'(W_ISO - 1);
    localparam logic [CNT_W-1:0] LD_SETTLE = CNT_W'(W_SETTLE - 1);

    typedef struct packed {
        seq_state_e        st;
        logic              pwr;
        logic              iso;
        logic              en;
        logic              rstb;
        logic              tun;
        logic              chg;
        logic              was_en;
        logic              done;
        logic              err;
        logic [PDIV_W-1:0] pdiv;
        logic [PDIV_W-1:0] pend_pdiv;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] pend_word;
    } seq_regs_t;

    seq_regs_t         d, q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic [PDIV_W-1:0] enc_code;
    logic              idle;
    seq_op_e           op;

    pll_seq_wait #(.CNT_W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    pll_seq_pdiv_enc #(.CODE_W(PDIV_W)) u_enc (
        .ratio (cmd_ratio),
        .code  (enc_code)
    );

    assign idle = (q.st == S_OFF) || (q.st == S_ON);
    assign op   = seq_op_e'(cmd_op);

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (cmd_valid && !idle) d.err = 1'b1;
        case (q.st)
            S_OFF, S_ON: begin
                if (cmd_valid) begin
                    if (op == OP_UP && q.st == S_OFF) begin
                        d.pwr    = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = LD_PON;
                        d.st     = S_UP_PWR;
                    end else if (op == OP_DOWN && q.st == S_ON) begin
                        d.rstb = 1'b0;
                        d.st   = S_DN_TUN;
                    end else if (op == OP_RETUNE) begin
                        d.tun       = 1'b0;
                        d.was_en    = q.en;
                        d.pend_pdiv = enc_code;
                        d.pend_word = cmd_word;
                        d.st        = S_RT_PDIV;
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            S_UP_PWR: if (tmr_exp) begin
                d.iso    = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = LD_ISO;
                d.st     = S_UP_ISO;
            end
            S_UP_ISO: if (tmr_exp) begin
                d.en = 1'b1;
                d.st = S_UP_TUN;
            end
            S_UP_TUN: begin
                d.tun    = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = LD_SETTLE;
                d.st     = S_UP_SETTLE;
            end
            S_UP_SETTLE: if (tmr_exp) begin
                d.rstb = HAS_RSTB;
                d.done = 1'b1;
                d.st   = S_ON;
            end
            S_DN_TUN: begin d.tun = 1'b0; d.st = S_DN_EN;  end
            S_DN_EN:  begin d.en  = 1'b0; d.st = S_DN_ISO; end
            S_DN_ISO: begin d.iso = 1'b1; d.st = S_DN_PWR; end
            S_DN_PWR: begin
                d.pwr  = 1'b0;
                d.done = 1'b1;
                d.st   = S_OFF;
            end
            S_RT_PDIV: begin
                d.pdiv = q.pend_pdiv;
                d.st   = S_RT_WORD;
            end
            S_RT_WORD: begin
                d.word = q.pend_word;
                d.chg  = q.was_en;
                d.st   = S_RT_TUN;
            end
            S_RT_TUN: begin
                d.tun = q.was_en;
                if (q.was_en) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETTLE;
                    d.st     = S_RT_SETTLE;
                end else begin
                    d.done = 1'b1;
                    d.st   = S_OFF;
                end
            end
            S_RT_SETTLE: if (tmr_exp) begin
                d.chg  = 1'b0;
                d.done = 1'b1;
                d.st   = S_ON;
            end
            default: d.st = S_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= S_OFF;
            q.iso <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pwr_on     = q.pwr;
    assign iso_en     = q.iso;
    assign pll_en     = q.en;
    assign rst_b      = q.rstb;
    assign tuner_en   = q.tun;
    assign chg_strobe = q.chg;
    assign pdiv_code  = q.pdiv;
    assign pll_word   = q.word;
    assign busy       = !idle;
    assign done       = q.done;
    assign cmd_err    = q.err;
    assign pll_ready  = (q.st == S_ON);
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic pwr_on,
    input logic iso_en,
    input logic pll_en,
    input logic rst_b,
    input logic tuner_en,
    input logic chg_strobe,
    input logic done,
    input logic cmd_err,
    input logic pll_ready
);
    // R2: isolation drops only with supply on
    a_r2_iso_after_pwr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> pwr_on);
    // R2: enable rises only with supply on and isolation off
    a_r2_en_after_iso: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> (pwr_on && !iso_en));
    // R3: reset release only while enabled
    a_r3_rstb_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        rst_b |-> pll_en);
    // R4: isolation returns only after enable is off
    a_r4_iso_after_en_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iso_en) |-> !pll_en);
    // R4: supply drops only while isolated
    a_r4_pwr_off_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_on) |-> iso_en);
    // R5: strobe rises only on an enabled PLL with tuner off
    a_r5_strobe_when_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_strobe) |-> (pll_en && !tuner_en));
    // R7: strobe only during a sequence
    a_r7_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        chg_strobe |-> busy);
    // R8: a command while busy is rejected
    a_r8_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> cmd_err);
    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: ready excludes busy
    a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pll_ready |-> (!busy && pll_en));
endmodule

bind pll_seq pll_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .busy       (busy),
    .pwr_on     (pwr_on),
    .iso_en     (iso_en),
    .pll_en     (pll_en),
    .rst_b      (rst_b),
    .tuner_en   (tuner_en),
    .chg_strobe (chg_strobe),
    .done       (done),
    .cmd_err    (cmd_err),
    .pll_ready  (pll_ready)
);

// File: tb/pll_seq_test.sv
module pll_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 22;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'd0;
    logic [WORD_W-1:0] cmd_word = '0;
    logic [7:0]        cmd_ratio = '0;
    logic              pwr_on, iso_en, pll_en, rst_b, tuner_en, chg_strobe;
    logic [2:0]        pdiv_code;
    logic [WORD_W-1:0] pll_word;
    logic              busy, done, cmd_err, pll_ready;

    int checks = 0;
    int failures = 0;
    int f_pwr, f_iso, f_en, f_rstb, f_tun, f_tunb, f_chg, f_chgf;
    int f_pdiv, f_word, f_done, f_err, f_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_word(cmd_word), .cmd_ratio(cmd_ratio), .pwr_on(pwr_on),
        .iso_en(iso_en), .pll_en(pll_en), .rst_b(rst_b), .tuner_en(tuner_en),
        .chg_strobe(chg_strobe), .pdiv_code(pdiv_code), .pll_word(pll_word),
        .busy(busy), .done(done), .cmd_err(cmd_err), .pll_ready(pll_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one command and record the first offset at which each output changes.
    task automatic watch(input logic [1:0] op, input logic [WORD_W-1:0] w,
                         input logic [7:0] r, input int maxk);
        logic s_pwr, s_iso, s_en, s_rstb, s_tun;
        logic [2:0] s_pdiv;
        logic [WORD_W-1:0] s_word;
        s_pwr = pwr_on; s_iso = iso_en; s_en = pll_en; s_rstb = rst_b;
        s_tun = tuner_en; s_pdiv = pdiv_code; s_word = pll_word;
        f_pwr = -1; f_iso = -1; f_en = -1; f_rstb = -1; f_tun = -1; f_tunb = -1;
        f_chg = -1; f_chgf = -1; f_pdiv = -1; f_word = -1; f_done = -1;
        f_err = -1; f_busy = -1;
        cmd_valid = 1'b1; cmd_op = op; cmd_word = w; cmd_ratio = r;
        for (int k = 1; k <= maxk; k++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (f_pwr  < 0 && pwr_on  != s_pwr)  f_pwr  = k;
            if (f_iso  < 0 && iso_en  != s_iso)  f_iso  = k;
            if (f_en   < 0 && pll_en  != s_en)   f_en   = k;
            if (f_rstb < 0 && rst_b   != s_rstb) f_rstb = k;
            if (f_pdiv < 0 && pdiv_code != s_pdiv) f_pdiv = k;
            if (f_word < 0 && pll_word  != s_word) f_word = k;
            if (f_tun < 0 && tuner_en != s_tun) f_tun = k;
            else if (f_tun >= 0 && f_tunb < 0 && tuner_en == s_tun) f_tunb = k;
            if (f_chg < 0 && chg_strobe) f_chg = k;
            else if (f_chg >= 0 && f_chgf < 0 && !chg_strobe) f_chgf = k;
            if (f_busy < 0 && busy) f_busy = k;
            if (done)    begin f_done = k; break; end
            if (cmd_err) begin f_err = k;  break; end
        end
    endtask

    task automatic t_reset;
        chk("R1 pwr_on", pwr_on, 0);
        chk("R1 iso_en", iso_en, 1);
        chk("R1 pll_en", pll_en, 0);
        chk("R1 rst_b", rst_b, 0);
        chk("R1 tuner_en", tuner_en, 0);
        chk("R1 chg_strobe", chg_strobe, 0);
        chk("R1 busy", busy, 0);
        chk("R1 pll_ready", pll_ready, 0);
        chk("R1 pdiv_code", pdiv_code, 0);
        chk("R1 pll_word", int'(pll_word), 0);
    endtask

    task automatic t_power_up;
        watch(2'd1, '0, '0, 400);
        chk("R2 pwr_on offset", f_pwr, 1);
        chk("R2 iso_en offset", f_iso, 11);
        chk("R2 pll_en offset", f_en, 21);
        chk("R2 tuner_en offset", f_tun, 22);
        chk("R3 rst_b offset", f_rstb, 222);
        chk("R9 busy offset", f_busy, 1);
        chk("R9 done offset", f_done, 222);
        chk("R9 busy at end", busy, 0);
        chk("R10 ready after up", pll_ready, 1);
    endtask

    task automatic t_retune_on;
        watch(2'd3, 22'h2A5A5, 8'h10, 400);
        chk("R5 tuner off offset", f_tun, 1);
        chk("R5 pdiv offset", f_pdiv, 2);
        chk("R5 word offset", f_word, 3);
        chk("R5 strobe offset", f_chg, 3);
        chk("R7 tuner back offset", f_tunb, 4);
        chk("R7 strobe clear offset", f_chgf, 204);
        chk("R7 done offset", f_done, 204);
        chk("R6 pdiv for ratio 16", pdiv_code, 4);
        chk("R5 word value", int'(pll_word), 32'h2A5A5);
        chk("R10 ready after retune", pll_ready, 1);
    endtask

    task automatic t_busy_reject;
        int k;
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_word = 22'h1234; cmd_ratio = 8'h02;
        @(negedge clk); cmd_valid = 1'b0;
        @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd1;
        @(negedge clk); cmd_valid = 1'b0;
        chk("R8 err while busy", cmd_err, 1);
        chk("R8 pwr unchanged", pwr_on, 1);
        chk("R10 ready low while busy", pll_ready, 0);
        k = 3;
        while (!done && k < 400) begin
            @(negedge clk);
            k++;
        end
        chk("R7 done unaffected by reject", k, 204);
        chk("R6 pdiv for ratio 2", pdiv_code, 1);
    endtask

    task automatic t_illegal_on;
        watch(2'd1, '0, '0, 5);
        chk("R8 up while on err", f_err, 1);
        chk("R8 up while on no pwr change", f_pwr, -1);
        chk("R8 up while on not busy", f_busy, -1);
        watch(2'd0, '0, '0, 5);
        chk("R8 op 0 err", f_err, 1);
        @(negedge clk);
        chk("R8 err single pulse", cmd_err, 0);
    endtask

    task automatic t_power_down;
        watch(2'd2, '0, '0, 20);
        chk("R4 rst_b offset", f_rstb, 1);
        chk("R4 tuner offset", f_tun, 2);
        chk("R4 pll_en offset", f_en, 3);
        chk("R4 iso offset", f_iso, 4);
        chk("R4 pwr offset", f_pwr, 5);
        chk("R9 done offset down", f_done, 5);
        chk("R10 ready after down", pll_ready, 0);
    endtask

    task automatic t_retune_off;
        watch(2'd3, 22'h3FFFF, 8'h80, 20);
        chk("R7 stopped tuner stays off", f_tun, -1);
        chk("R7 stopped no strobe", f_chg, -1);
        chk("R5 stopped pdiv offset", f_pdiv, 2);
        chk("R5 stopped word offset", f_word, 3);
        chk("R7 stopped done offset", f_done, 4);
        chk("R7 stopped pwr stays off", pwr_on, 0);
        chk("R6 pdiv for ratio 128", pdiv_code, 7);
        watch(2'd3, 22'h1, 8'h06, 20);
        chk("R6 pdiv highest bit of 6", pdiv_code, 2);
        watch(2'd3, 22'h1, 8'h00, 20);
        chk("R6 pdiv for ratio 0", pdiv_code, 0);
        watch(2'd2, '0, '0, 5);
        chk("R8 down while off err", f_err, 1);
        chk("R8 down while off iso kept", iso_en, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_power_up();
        t_retune_on();
        t_busy_reject();
        t_illegal_on();
        t_power_down();
        t_retune_off();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule